// File: doc/BRIEF.md
# Continuous Self-Test Fault Monitor

This block watches a sensor's self-test while the sensor keeps producing data. The sensing path applies alternating positive and negative equivalent-rate stimuli, faster than the output bandwidth. The block receives the resulting deflection samples one at a time, each tagged with its polarity. When a negative sample follows a held positive sample, the block takes their difference. A first-order IIR low-pass filter then smooths that difference with a time constant of roughly 8000 pair updates.

After every filter update, the new filtered amplitude is judged against two fixed signed windows, and the severe window strictly encloses the mild one. Leaving the mild window raises a sticky fault flag. Leaving the severe window also drives the 2-bit data-validity code to "invalid". The filtered amplitude and the fault word can be read through a small register read port. Reading the fault word clears the flag. After reset the filter starts at a nominal midpoint, and judging is held off for a configurable number of updates while the filter settles.

Top module: `cst_monitor`

## Requirements
- R1: A valid sample with `samp_pos_i`=1 is held; a later positive replaces it. A valid sample with `samp_pos_i`=0 while a positive is held forms diff = pos − neg (signed), triggers exactly one filter update and releases the held positive. A negative sample with no held positive is ignored.
- R2: The filter accumulator resets to NOMINAL·2^K. Each update applies acc ← acc + diff − floor(acc/2^K). The filtered value is floor(acc/2^K).
- R3: A read with `rd_en_i`=1 and `rd_addr_i`=0x04 returns the filtered value as it stood before that clock edge, sign-extended to RDW bits, one cycle later with `rd_valid_o`=1. `rd_valid_o` is 1 exactly in the cycle after each read request.
- R4: The first WARMUP filter updates after reset are not judged. During them `fault_o` does not change and `status_o` stays 2'b01.
- R5: A judged update whose new filtered value lies outside [MILD_LO, MILD_HI] (inclusive inside) sets `fault_o`. While the value stays within [SEVERE_LO, SEVERE_HI], `status_o` is 2'b01.
- R6: A judged update whose new filtered value lies outside [SEVERE_LO, SEVERE_HI] sets `fault_o` and drives `status_o` to 2'b00.
- R7: `status_o` follows the latest judged update only: 2'b00 when that update was outside the severe window, 2'b01 otherwise. Its only values are 2'b01 and 2'b00.
- R8: `fault_o` stays set until a read at address 0x05. That read returns the flag in bit 0, with all other bits zero, as it stood before the edge, and clears the flag. A judged mild violation on the same edge takes priority and leaves the flag set.
- R9: After reset `fault_o`=0, `status_o`=2'b01 and `rd_valid_o`=0, and a read at 0x04 returns NOMINAL.
- R10: A read at any address other than 0x04 and 0x05 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| samp_valid_i | input | 1 | Deflection sample present this cycle |
| samp_pos_i | input | 1 | 1: positive-stimulus sample, 0: negative-stimulus sample |
| samp_i | input | DW | Signed deflection sample |
| rd_en_i | input | 1 | Register read request |
| rd_addr_i | input | 8 | Register read address |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | RDW | Read data |
| fault_o | output | 1 | Sticky self-test fault flag |
| status_o | output | 2 | Data-validity code: 2'b01 valid, 2'b00 invalid |

## Verification
A negative sample that completes a pair updates the filter, the fault flag and the status code on the same clock edge. The bench therefore drives each sample on a falling edge and compares all three results at the next falling edge. Read data and `rd_valid_o` become due one edge after the request, and they carry the state from before that edge. The arithmetic model in the bench follows that ordering: it forms the expected read data from its pre-edge state, then applies the sample and the clear, and only then compares the flag and the code. A reduced configuration (8-bit samples, K=2, three warm-up updates) lets a sweep of pair differences cross both windows on both sides many times within the run.

// File: rtl/cst_pkg.sv
package cst_pkg;
  typedef enum logic [1:0] {
    ST_INVALID = 2'b00,
    ST_VALID   = 2'b01
  } status_e;

  localparam int          ADDR_W     = 8;
  localparam logic [7:0]  ADDR_VALUE = 8'h04;
  localparam logic [7:0]  ADDR_FAULT = 8'h05;
endpackage

// File: rtl/cst_pair_former.sv
module cst_pair_former #(
  parameter int DW = 12,
  localparam int FW = DW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 samp_valid_i,
  input  logic                 samp_pos_i,
  input  logic signed [DW-1:0] samp_i,
  output logic                 pair_o,
  output logic signed [FW-1:0] diff_o
);
  logic                 held_q;
  logic signed [DW-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      pos_q  <= '0;
    end else if (samp_valid_i) begin
      if (samp_pos_i) begin
        held_q <= 1'b1;
        pos_q  <= samp_i;
      end else if (held_q) begin
        held_q <= 1'b0;
      end
    end
  end

  assign pair_o = samp_valid_i && !samp_pos_i && held_q;
  assign diff_o = {pos_q[DW-1], pos_q} - {samp_i[DW-1], samp_i};

  // R1
  pair_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_o |=> !held_q);

  // R1
  orphan_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_valid_i && !samp_pos_i && !held_q) |=> !held_q);
endmodule

// File: rtl/cst_iir.sv
module cst_iir #(
  parameter int DW      = 12,
  parameter int K       = 13,
  parameter int NOMINAL = 400,
  localparam int FW = DW + 1,
  localparam int AW = DW + 2 + K
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 upd_i,
  input  logic signed [FW-1:0] x_i,
  output logic signed [FW-1:0] y_o,
  output logic signed [FW-1:0] y_next_o
);
  localparam logic signed [AW-1:0] ACC_RST = AW'(NOMINAL) <<< K;

  logic signed [AW-1:0] acc_q, acc_d, x_ext;

  assign x_ext = {{(AW-FW){x_i[FW-1]}}, x_i};
  assign acc_d = acc_q + x_ext - (acc_q >>> K);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= ACC_RST;
    else if (upd_i) acc_q <= acc_d;
  end

  assign y_o      = acc_q[K +: FW];
  assign y_next_o = acc_d[K +: FW];

  // R2
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(acc_q));
endmodule

// File: rtl/cst_band_judge.sv
module cst_band_judge #(
  parameter int FW        = 13,
  parameter int MILD_LO   = 300,
  parameter int MILD_HI   = 500,
  parameter int SEVERE_LO = 200,
  parameter int SEVERE_HI = 600
) (
  input  logic signed [FW-1:0] y_i,
  output logic                 mild_out_o,
  output logic                 severe_out_o
);
  localparam logic signed [FW-1:0] MLO = FW'(MILD_LO);
  localparam logic signed [FW-1:0] MHI = FW'(MILD_HI);
  localparam logic signed [FW-1:0] SLO = FW'(SEVERE_LO);
  localparam logic signed [FW-1:0] SHI = FW'(SEVERE_HI);

  assign mild_out_o   = (y_i < MLO) || (y_i > MHI);
  assign severe_out_o = (y_i < SLO) || (y_i > SHI);
endmodule

// File: rtl/cst_fault_ctrl.sv
module cst_fault_ctrl
  import cst_pkg::*;
#(
  parameter int WARMUP = 32768,
  localparam int CW = $clog2(WARMUP + 2)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_i,
  input  logic       mild_i,
  input  logic       severe_i,
  input  logic       clr_i,
  output logic       fault_o,
  output logic [1:0] status_o
);
  logic [CW-1:0] cnt_q;
  logic          armed;
  logic          fault_q;
  status_e       status_q;

  assign armed = (cnt_q == CW'(WARMUP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      fault_q  <= 1'b0;
      status_q <= ST_VALID;
    end else begin
      if (upd_i && !armed) cnt_q <= cnt_q + 1'b1;
      // set beats clear
      if (upd_i && armed && mild_i) fault_q <= 1'b1;
      else if (clr_i)               fault_q <= 1'b0;
      if (upd_i && armed) status_q <= severe_i ? ST_INVALID : ST_VALID;
    end
  end

  assign fault_o  = fault_q;
  assign status_o = status_q;

  // R4
  warm_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !armed && !clr_i) |=> ($stable(fault_q) && status_q == ST_VALID));

  // R4
  armed_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |=> armed);

  // R6
  severe_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && armed && severe_i) |=> (fault_q && status_q == ST_INVALID));

  // R5
  band_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    severe_i |-> mild_i);

  // R7
  status_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q == ST_VALID) || (status_q == ST_INVALID));

  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && !clr_i) |=> fault_q);
endmodule

// File: rtl/cst_monitor.sv
module cst_monitor
  import cst_pkg::*;
#(
  parameter int DW        = 12,
  parameter int K         = 13,
  parameter int NOMINAL   = 400,
  parameter int MILD_LO   = 300,
  parameter int MILD_HI   = 500,
  parameter int SEVERE_LO = 200,
  parameter int SEVERE_HI = 600,
  parameter int WARMUP    = 32768,
  parameter int RDW       = 16,
  localparam int FW = DW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              samp_valid_i,
  input  logic              samp_pos_i,
  input  logic [DW-1:0]     samp_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_valid_o,
  output logic [RDW-1:0]    rd_data_o,
  output logic              fault_o,
  output logic [1:0]        status_o
);
  logic                 pair;
  logic signed [FW-1:0] diff, y, y_next;
  logic                 mild_out, severe_out, clr;
  logic [RDW-1:0]       y_ext, rd_mux;
  logic                 rd_valid_q;
  logic [RDW-1:0]       rd_data_q;

  cst_pair_former #(.DW(DW)) u_pair (
    .clk_i, .rst_ni,
    .samp_valid_i, .samp_pos_i,
    .samp_i  (samp_i),
    .pair_o  (pair),
    .diff_o  (diff)
  );

  cst_iir #(.DW(DW), .K(K), .NOMINAL(NOMINAL)) u_iir (
    .clk_i, .rst_ni,
    .upd_i    (pair),
    .x_i      (diff),
    .y_o      (y),
    .y_next_o (y_next)
  );

  cst_band_judge #(
    .FW(FW), .MILD_LO(MILD_LO), .MILD_HI(MILD_HI),
    .SEVERE_LO(SEVERE_LO), .SEVERE_HI(SEVERE_HI)
  ) u_judge (
    .y_i          (y_next),
    .mild_out_o   (mild_out),
    .severe_out_o (severe_out)
  );

  assign clr = rd_en_i && (rd_addr_i == ADDR_FAULT);

  cst_fault_ctrl #(.WARMUP(WARMUP)) u_fault (
    .clk_i, .rst_ni,
    .upd_i    (pair),
    .mild_i   (mild_out),
    .severe_i (severe_out),
    .clr_i    (clr),
    .fault_o  (fault_o),
    .status_o (status_o)
  );

  generate
    if (RDW > FW) begin : g_sext
      assign y_ext = {{(RDW-FW){y[FW-1]}}, y};
    end else begin : g_trunc
      assign y_ext = y[RDW-1:0];
    end
  endgenerate

  always_comb begin
    unique case (rd_addr_i)
      ADDR_VALUE: rd_mux = y_ext;
      ADDR_FAULT: rd_mux = {{(RDW-1){1'b0}}, fault_o};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en_i;
      if (rd_en_i) rd_data_q <= rd_mux;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  // R3
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  // R3
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
endmodule

// File: tb/cst_monitor_bench.sv
module cst_monitor_bench;
  localparam int DW = 8, K = 2, NOM = 20;
  localparam int MLO = 10, MHI = 30, SLO = 0, SHI = 40, WU = 3, RDW = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic samp_valid = 1'b0, samp_pos = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] samp = '0;
  logic [7:0] rd_addr = '0;
  logic rd_valid, fault;
  logic [RDW-1:0] rd_data;
  logic [1:0] status;

  int checks = 0, fails = 0, cycles = 0;
  int m_acc, m_cnt, m_pos;
  bit m_held, m_fault;
  logic [1:0] m_status;

  always #4 clk = ~clk;

  cst_monitor #(
    .DW(DW), .K(K), .NOMINAL(NOM), .MILD_LO(MLO), .MILD_HI(MHI),
    .SEVERE_LO(SLO), .SEVERE_HI(SHI), .WARMUP(WU), .RDW(RDW)
  ) u_cst_monitor (
    .clk_i(clk), .rst_ni(rst_ni),
    .samp_valid_i(samp_valid), .samp_pos_i(samp_pos), .samp_i(samp),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .fault_o(fault), .status_o(status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // one cycle: optional sample and optional read, then compare against model
  task automatic step(input string tag, input bit sv, input bit pol, input int val,
                      input bit re, input int addr);
    int exp_rd, y;
    bit set;
    samp_valid = sv; samp_pos = pol; samp = DW'(val);
    rd_en = re; rd_addr = 8'(addr);
    exp_rd = (addr == 4) ? (m_acc >>> K) : (addr == 5) ? int'(m_fault) : 0;
    set = 1'b0;
    if (sv) begin
      if (pol) begin
        m_held = 1'b1; m_pos = val;
      end else if (m_held) begin
        m_held = 1'b0;
        m_acc = m_acc + (m_pos - val) - (m_acc >>> K);
        if (m_cnt < WU) m_cnt++;
        else begin
          y = m_acc >>> K;
          set = (y < MLO) || (y > MHI);
          m_status = ((y < SLO) || (y > SHI)) ? 2'b00 : 2'b01;
        end
      end
    end
    if (set) m_fault = 1'b1;
    else if (re && addr == 5) m_fault = 1'b0;
    @(negedge clk);
    samp_valid = 1'b0; rd_en = 1'b0;
    chk({tag, " fault"}, int'(fault), int'(m_fault));
    chk({tag, " status"}, int'(status), int'(m_status));
    chk({tag, " rd_valid"}, int'(rd_valid), int'(re));
    if (re) chk({tag, " rd_data"}, int'($signed(rd_data)), exp_rd);
  endtask

  task automatic pair(input string tag, input int p, input int n, input bit re, input int addr);
    step(tag, 1'b1, 1'b1, p, 1'b0, 0);
    step(tag, 1'b1, 1'b0, n, re, addr);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    m_acc = NOM <<< K; m_cnt = 0; m_pos = 0;
    m_held = 1'b0; m_fault = 1'b0; m_status = 2'b01;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 fault", int'(fault), 0);
    chk("R9 status", int'(status), 1);
    chk("R9 rd_valid", int'(rd_valid), 0);
    step("R9 R3 read nominal", 0, 0, 0, 1, 4);
    step("R8 read clear fault", 0, 0, 0, 1, 5);
    step("R10 other addr", 0, 0, 0, 1, 7);
    step("R10 other addr", 0, 0, 0, 1, 0);
    // R1 orphan negative ignored, filter unchanged
    step("R1 orphan neg", 1, 0, 50, 0, 0);
    step("R1 orphan readback", 0, 0, 0, 1, 4);
    // R4 warm-up: large diffs unjudged
    for (int i = 0; i < WU; i++) pair("R4 warmup", 60, -40, 1'b1, 4);
    // first judged update, severe
    pair("R6 severe high", 10, -10, 1'b1, 4);
    // R7 recover status, fault sticky (R8)
    for (int i = 0; i < 8; i++) pair("R7 R8 recover", 10, -10, 1'b0, 0);
    step("R8 read fault", 0, 0, 0, 1, 5);
    step("R8 fault cleared", 0, 0, 0, 1, 5);
    // R5 mild-only excursion
    for (int i = 0; i < 10; i++) pair("R5 mild high", 20, -14, 1'b0, 0);
    step("R5 clear", 0, 0, 0, 1, 5);
    // R8 set wins over same-edge clear
    pair("R8 set beats clear", 20, -14, 1'b1, 5);
    step("R8 after race", 0, 0, 0, 1, 5);
    // R1 second positive replaces first
    step("R1 pos a", 1, 1, 10, 0, 0);
    step("R1 pos b", 1, 1, 50, 0, 0);
    step("R1 neg", 1, 0, 20, 1, 4);
    step("R1 R2 readback", 0, 0, 0, 1, 4);
    // sweep differences through both windows on both sides
    for (int d = -60; d <= 100; d += 8)
      for (int i = 0; i < 6; i++) begin
        pair("R2 R5 R6 R7 sweep", d / 2, d / 2 - d, 1'b1, (i == 5) ? 5 : 4);
      end
    for (int d = 100; d >= -60; d -= 12)
      for (int i = 0; i < 5; i++) pair("R2 R7 sweep down", d / 2, d / 2 - d, 1'b1, 4);
    finish_run();
  end
endmodule